// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single transmit line. Software, or a bus front end that is not part of this block, writes a byte into a one-entry holding stage with a load strobe. When the shift stage is free, the byte moves into it. The frame then leaves on the line: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period.

The frame shape comes from an 8-bit format word:

| Bits | Meaning |
|------|---------|
| `fmt[1:0]` | Character length, from 5 to 8 bits |
| `fmt[2]` | Long stop period |
| `fmt[3]` | Parity enable |
| `fmt[4]` | Even parity when set |
| `fmt[6]` | Break: holds the line low |

The block samples the format word once per character, at the moment the byte enters the shift stage. Timing is paced by a one-clock enable pulse at sixteen times the baud rate. The baud divisor that makes this pulse lies outside the block.

Two flags report the state of the stages. `hold_empty` shows that another byte may be written. `shift_empty` shows that the transmitter has fully drained.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high, and after it, the line is at the marking level (`txd`=1) and both `hold_empty` and `shift_empty` are 1. This holds even when reset arrives in the middle of a frame.
- R2: A frame is a start bit of 0, then the data bits from bit 0 upward, then a stop level of 1. `fmt[1:0]` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the selected length are never sent.
- R3: With `fmt[3]`=1, one parity bit follows the data. With `fmt[4]`=1 the count of ones over data and parity is even; with `fmt[4]`=0 it is odd. With `fmt[3]`=0 no parity bit is sent.
- R4: Start, data and parity bits each last exactly 16 clock edges on which `tick16` is high. Clocks with `tick16` low do not advance the frame.
- R5: With `fmt[2]`=0 the stop period lasts 16 ticks. With `fmt[2]`=1 it lasts 24 ticks for a 5-bit character and 32 ticks for longer characters. `shift_empty` rises on the tick edge that ends the stop period.
- R6: `hold_empty` falls on the clock edge that samples `hold_load`. On the first clock edge at which the shift stage is idle, the held byte moves into it. On that same edge `hold_empty` rises and the start bit begins.
- R7: `shift_empty` is 1 only when the holding stage is empty and no frame is in progress.
- R8: Changes to `fmt[4:0]` after a frame has started have no effect on that frame's length, parity or stop period.
- R9: `fmt[6]`=1 drives `txd` to 0 at once, whether the block is idle or mid-frame. Frame timing carries on underneath, and the line shows the frame's current level again when the bit clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| hold_data | input | 8 | Byte to transmit |
| hold_load | input | 1 | Writes `hold_data` into the holding stage |
| fmt | input | 8 | Format word (length, stop, parity enable, parity sense, break) |
| txd | output | 1 | Serial transmit line |
| hold_empty | output | 1 | Holding stage can accept a byte |
| shift_empty | output | 1 | Both stages idle |

## Verification
A wrong bit index or a wrong shift register shows as a wrong level at the middle of the affected bit, within eight ticks of the fault. An off-by-one in the tick counter moves every later bit edge. The first mid-bit sample misses that shift only once the error has built up, but the exact tick on which `shift_empty` rises exposes it at the end of the frame. A flaw in the handover between the stages shows within one clock of the event, as a wrong `hold_empty` or `shift_empty` level or a missing start bit.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic [7:0] hold_data,
  input  logic       hold_load,
  input  logic [7:0] fmt,
  output logic       txd,
  output logic       hold_empty,
  output logic       shift_empty
);

  localparam int CW = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CW-1:0] BIT_LAST  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [1:0] {PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  logic          hold_full;
  logic [7:0]    hold_q;
  logic          busy;
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [7:0]    shreg;
  logic [2:0]    bits_left;
  logic          par_en;
  logic          par_bit;
  logic [CW-1:0] stop_last;

  logic          fmt_unused;
  assign fmt_unused = ^{fmt[7], fmt[5]};

  logic          take;
  logic [7:0]    len_mask;
  logic          bit_end;
  logic          line_bit;

  assign take     = !busy && hold_full;
  assign len_mask = 8'hFF >> (2'd3 - fmt[1:0]);
  assign bit_end  = (phase == PH_STOP) ? (cnt == stop_last) : (cnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      phase     <= PH_STOP;
      cnt       <= '0;
      bits_left <= '0;
      par_en    <= 1'b0;
      par_bit   <= 1'b0;
      stop_last <= BIT_LAST;
      shreg     <= 8'hFF;
    end else begin
      if (hold_load) begin
        hold_q    <= hold_data;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end

      if (take) begin
        busy      <= 1'b1;
        phase     <= PH_START;
        cnt       <= '0;
        shreg     <= hold_q;
        bits_left <= 3'd4 + {1'b0, fmt[1:0]};
        par_en    <= fmt[3];
        par_bit   <= (^(hold_q & len_mask)) ^ ~fmt[4];
        if (!fmt[2])
          stop_last <= BIT_LAST;
        else if (fmt[1:0] == 2'b00)
          stop_last <= HALF_LAST;
        else
          stop_last <= TWO_LAST;
      end else if (busy && tick16) begin
        if (!bit_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          case (phase)
            PH_START: phase <= PH_DATA;
            PH_DATA: begin
              if (bits_left == 3'd0) begin
                phase <= par_en ? PH_PAR : PH_STOP;
              end else begin
                shreg     <= shreg >> 1;
                bits_left <= bits_left - 1'b1;
              end
            end
            PH_PAR:  phase <= PH_STOP;
            default: busy  <= 1'b0;
          endcase
        end
      end
    end
  end

  always_comb begin
    line_bit = 1'b1;
    if (busy) begin
      case (phase)
        PH_START: line_bit = 1'b0;
        PH_DATA:  line_bit = shreg[0];
        PH_PAR:   line_bit = par_bit;
        default:  line_bit = 1'b1;
      endcase
    end
  end

  assign txd         = line_bit & ~fmt[6];
  assign hold_empty  = ~hold_full;
  assign shift_empty = ~hold_full & ~busy;

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick16,
  input logic hold_load,
  input logic brk,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic busy
);

  AST_DRAINED_MEANS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> hold_empty); // R7

  AST_IDLE_MARKING: assert property (@(posedge clk) disable iff (rst)
    (shift_empty && !brk) |-> txd); // R1

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
    hold_load |=> !hold_empty); // R6

  AST_HANDOVER_STARTS: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> !txd); // R2

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick16 && !brk) |=> (brk || $stable(txd))); // R4

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .hold_load(hold_load), .brk(fmt[6]),
  .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .busy(busy)
);

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int NVEC       = 10;

  // {fmt, data, frame bits before stop, stop ticks, parity bit}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h03, 8'hA5, 4'd9,  6'd16, 1'b0},
    {8'h00, 8'h1F, 4'd6,  6'd16, 1'b0},
    {8'h04, 8'h0A, 4'd6,  6'd24, 1'b0},
    {8'h07, 8'h3C, 4'd9,  6'd32, 1'b0},
    {8'h1B, 8'h07, 4'd10, 6'd16, 1'b1},
    {8'h0B, 8'h07, 4'd10, 6'd16, 1'b0},
    {8'h0A, 8'h81, 4'd9,  6'd16, 1'b0},
    {8'h19, 8'hC0, 4'd8,  6'd16, 1'b0},
    {8'h1C, 8'hE1, 4'd7,  6'd24, 1'b1},
    {8'h0E, 8'h55, 4'd9,  6'd32, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic tick_en = 1'b1;
  logic hold_load = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic [7:0] fmt = 8'h03;
  logic txd, hold_empty, shift_empty;
  int tdiv = 0;
  int checks = 0;
  int errors = 0;

  serial_frame_tx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .hold_data(hold_data),
    .hold_load(hold_load), .fmt(fmt), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!tick_en) begin
      tdiv   <= 0;
      tick16 <= 1'b0;
    end else if (tdiv == TICK_DIV - 1) begin
      tdiv   <= 0;
      tick16 <= 1'b1;
    end else begin
      tdiv   <= tdiv + 1;
      tick16 <= 1'b0;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick_edges(int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick16) c++;
    end
  endtask

  task automatic load(logic [7:0] d);
    @(negedge clk);
    hold_data = d;
    hold_load = 1'b1;
    @(negedge clk);
    hold_load = 1'b0;
  endtask

  task automatic run_frame(logic [7:0] f, logic [7:0] f_mid, logic [7:0] d,
                           int nb, int stopt, logic par, string tag);
    int len;
    logic e;
    len = 5 + int'(f[1:0]);
    fmt = f;
    load(d);
    check("R6", {tag, " holding full after load"}, hold_empty, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R2", {tag, " start bit"}, txd, 1'b0);
    check("R6", {tag, " holding empty after handover"}, hold_empty, 1'b1);
    check("R7", {tag, " shifter busy"}, shift_empty, 1'b0);
    fmt = f_mid;
    for (int i = 0; i < nb; i++) begin
      tick_edges(8);
      @(negedge clk);
      if (i == 0) e = 1'b0;
      else if (i <= len) e = d[i-1];
      else e = par;
      check((i > len) ? "R3" : "R2", $sformatf("%s bit %0d", tag, i), txd, e);
      tick_edges(8);
    end
    tick_edges(8);
    @(negedge clk);
    check("R2", {tag, " stop level"}, txd, 1'b1);
    tick_edges(stopt - 9);
    @(negedge clk);
    check("R5", {tag, " busy one tick before stop end"}, shift_empty, 1'b0);
    tick_edges(1);
    @(negedge clk);
    check("R5", {tag, " drained at stop end"}, shift_empty, 1'b1);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R1", "reset txd", txd, 1'b1);
    check("R1", "reset hold_empty", hold_empty, 1'b1);
    check("R1", "reset shift_empty", shift_empty, 1'b1);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][26:19], VEC[v][26:19], VEC[v][18:11], int'(VEC[v][10:7]),
                int'(VEC[v][6:1]), VEC[v][0], $sformatf("vec%0d", v));

    // R8: format rewritten after the start bit
    run_frame(8'h03, 8'h1C, 8'hA5, 9, 16, 1'b0, "R8 midframe fmt");

    // R9: break while idle
    @(negedge clk);
    fmt = 8'h43;
    #1 check("R9", "break idle", txd, 1'b0);
    @(negedge clk);
    fmt = 8'h03;
    #1 check("R9", "break released idle", txd, 1'b1);

    // R9: break during a frame of ones, timing continues
    load(8'hFF);
    @(posedge clk);
    @(negedge clk);
    tick_edges(24);
    @(negedge clk);
    fmt = 8'h43;
    #1 check("R9", "break midframe", txd, 1'b0);
    tick_edges(16);
    @(negedge clk);
    check("R9", "break holds line", txd, 1'b0);
    fmt = 8'h03;
    #1 check("R9", "frame level after break", txd, 1'b1);
    tick_edges(16 * 7 + 16 - 1 - 8);
    @(negedge clk);
    check("R9", "frame end unshifted busy", shift_empty, 1'b0);
    tick_edges(1);
    @(negedge clk);
    check("R9", "frame end unshifted drained", shift_empty, 1'b1);

    // R4: no progress without ticks
    @(posedge clk);
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    load(8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R4", "start without ticks", txd, 1'b0);
    repeat (40) @(negedge clk);
    check("R4", "start held without ticks", txd, 1'b0);
    check("R4", "busy held without ticks", shift_empty, 1'b0);
    @(posedge clk);
    tick_en = 1'b1;
    tick_edges(15);
    @(negedge clk);
    check("R4", "start after 15 ticks", txd, 1'b0);
    tick_edges(1);
    @(negedge clk);
    check("R4", "data after 16 ticks", txd, 1'b1);
    while (!shift_empty) @(negedge clk);

    // R6 / R7: second byte queued while first is sent
    fmt = 8'h03;
    load(8'h0F);
    @(posedge clk);
    @(negedge clk);
    hold_data = 8'hF0;
    hold_load = 1'b1;
    @(posedge clk);
    c = tick16 ? 1 : 0;
    @(negedge clk);
    hold_load = 1'b0;
    check("R6", "queued byte fills holding", hold_empty, 1'b0);
    check("R7", "queued shifter busy", shift_empty, 1'b0);
    tick_edges(160 - 1 - c);
    @(negedge clk);
    check("R6", "still held before first end", hold_empty, 1'b0);
    check("R5", "stop before first end", txd, 1'b1);
    tick_edges(1);
    @(negedge clk);
    check("R7", "held byte keeps shift_empty low", shift_empty, 1'b0);
    check("R6", "held until handover edge", hold_empty, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R6", "handover empties holding", hold_empty, 1'b1);
    check("R6", "second start bit", txd, 1'b0);
    tick_edges(16 + 8);
    @(negedge clk);
    check("R2", "second frame bit0", txd, 1'b0);
    tick_edges(16 * 4);
    @(negedge clk);
    check("R2", "second frame bit4", txd, 1'b1);

    // R1: reset mid-frame
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "midframe reset txd", txd, 1'b1);
    check("R1", "midframe reset hold_empty", hold_empty, 1'b1);
    check("R1", "midframe reset shift_empty", shift_empty, 1'b1);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1", "after reset idle", txd, 1'b1);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule